// File: doc/BRIEF.md
# Idle Sleep Governor

The governor watches a busy/idle line from a device and decides, cycle by cycle, whether the device should be asked to enter its low-power state. It counts how long the current idle stretch has lasted. It also keeps a running prediction of how long idle stretches usually last. The break-even time is the sum of two programmed transition costs: the time to enter the low-power state and the time to leave it. Sleeping pays off only when an idle stretch outlasts this sum.

Software picks one of four policies with a 2-bit select:
- Immediate: request sleep as soon as the device goes idle.
- Fixed timeout: request sleep once the idle stretch reaches a programmed cycle count.
- Predictive: request sleep when the predicted idle length exceeds break-even.
- Off: never request sleep.

The request is combinational on the busy line, so it drops in the same cycle the device becomes busy. Two saturating statistics counters record completed idle periods. One counts every period. The other counts only the periods longer than break-even.

Top module: `idle_sleep_governor`

## Requirements
- R1: After reset the idle count, the prediction, both statistics counters and the sleep request are all zero.
- R2: The idle count rises by one at every clock edge with busy_i low and clears at every edge with busy_i high. It holds at its all-ones maximum instead of wrapping.
- R3: sleep_req_o is low in every cycle in which busy_i is high, whatever the policy.
- R4: With policy_i = 2'b00 (immediate), sleep_req_o is high in every cycle with busy_i low, including the first idle cycle.
- R5: With policy_i = 2'b01 (fixed timeout), sleep_req_o is high in an idle cycle exactly when the idle count (idle cycles already completed) is greater than or equal to timeout_i.
- R6: With policy_i = 2'b10 (predictive), sleep_req_o is high in an idle cycle exactly when pred_o is strictly greater than t_enter_i + t_exit_i.
- R7: With policy_i = 2'b11, sleep_req_o stays low.
- R8: An idle period ends at a clock edge where busy_i is high and the idle count is non-zero. Its length is the idle count at that edge. At that edge pred_o becomes pred − (pred >> 3) + (length >> 3), with each shift truncating. At all other edges pred_o holds.
- R9: long_cnt_o rises by one for each ended period whose length is strictly greater than t_enter_i + t_exit_i. A length equal to break-even does not count.
- R10: period_cnt_o rises by one for each ended idle period.
- R11: Both statistics counters hold at their all-ones maximum instead of wrapping.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| busy_i | input | 1 | Device busy (1) or idle (0) |
| policy_i | input | 2 | 00 immediate, 01 fixed timeout, 10 predictive, 11 off |
| timeout_i | input | CNT_W | Idle cycles before a fixed-timeout request |
| t_enter_i | input | TR_W | Cycles to enter the low-power state |
| t_exit_i | input | TR_W | Cycles to leave the low-power state |
| sleep_req_o | output | 1 | Sleep request |
| idle_cnt_o | output | CNT_W | Length of the current idle stretch |
| pred_o | output | CNT_W | Predicted idle length |
| long_cnt_o | output | STAT_W | Ended periods longer than break-even |
| period_cnt_o | output | STAT_W | Ended idle periods |

## Verification
The sleep request depends only on busy_i, policy_i and registered state, so it is due in the same cycle as a stimulus. The bench drives inputs at the falling edge and samples the request 1 ns later. The idle count, the prediction and both statistics counters change at the rising edge that sees the stimulus. The bench therefore reads them at the next falling edge, one edge after the busy cycle that closes a period. The bench keeps its own model of the prediction and the counters using the R8 to R10 formulas, and checks the request against that model in every idle cycle of each period.

// File: rtl/sgov_pkg.sv
package sgov_pkg;
  typedef enum logic [1:0] {
    POL_IMM  = 2'b00,
    POL_TMO  = 2'b01,
    POL_PRED = 2'b10,
    POL_OFF  = 2'b11
  } policy_e;
endpackage

// File: rtl/sgov_idle_tracker.sv
module sgov_idle_tracker #(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             busy_i,
  output logic [CNT_W-1:0] idle_cnt_o,
  output logic             period_end_o,
  output logic [CNT_W-1:0] period_len_o
);
  localparam logic [CNT_W-1:0] CntMax = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)             cnt_q <= '0;
    else if (busy_i)         cnt_q <= '0;
    else if (cnt_q != CntMax) cnt_q <= cnt_q + 1'b1;
  end

  assign idle_cnt_o   = cnt_q;
  assign period_end_o = busy_i && (cnt_q != '0);
  assign period_len_o = cnt_q;
endmodule

// File: rtl/sgov_predictor.sv
module sgov_predictor #(
  parameter int CNT_W = 16,
  parameter int SHIFT = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             upd_i,
  input  logic [CNT_W-1:0] len_i,
  output logic [CNT_W-1:0] pred_o
);
  logic [CNT_W-1:0] pred_q;
  logic [CNT_W-1:0] pred_d;

  // the decayed part never exceeds max - max/2^SHIFT, so no overflow
  always_comb pred_d = pred_q - (pred_q >> SHIFT) + (len_i >> SHIFT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    pred_q <= '0;
    else if (upd_i) pred_q <= pred_d;
  end

  assign pred_o = pred_q;
endmodule

// File: rtl/sgov_stat_cnt.sv
module sgov_stat_cnt #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  localparam logic [W-1:0] Max = {W{1'b1}};

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_q <= '0;
    else if (inc_i && cnt_q != Max) cnt_q <= cnt_q + 1'b1;
  end

  assign cnt_o = cnt_q;
endmodule

// File: rtl/sgov_policy.sv
module sgov_policy
  import sgov_pkg::*;
#(
  parameter int CMP_W = 17
) (
  input  logic             busy_i,
  input  policy_e          policy_i,
  input  logic [CMP_W-1:0] idle_cnt_i,
  input  logic [CMP_W-1:0] timeout_i,
  input  logic [CMP_W-1:0] pred_i,
  input  logic [CMP_W-1:0] brk_even_i,
  output logic             req_o
);
  logic allow;

  always_comb begin
    unique case (policy_i)
      POL_IMM:  allow = 1'b1;
      POL_TMO:  allow = idle_cnt_i >= timeout_i;
      POL_PRED: allow = pred_i > brk_even_i;
      default:  allow = 1'b0;
    endcase
  end

  assign req_o = allow && !busy_i;
endmodule

// File: rtl/idle_sleep_governor.sv
module idle_sleep_governor
  import sgov_pkg::*;
#(
  parameter int CNT_W      = 16,
  parameter int TR_W       = 12,
  parameter int STAT_W     = 16,
  parameter int PRED_SHIFT = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              busy_i,
  input  logic [1:0]        policy_i,
  input  logic [CNT_W-1:0]  timeout_i,
  input  logic [TR_W-1:0]   t_enter_i,
  input  logic [TR_W-1:0]   t_exit_i,
  output logic              sleep_req_o,
  output logic [CNT_W-1:0]  idle_cnt_o,
  output logic [CNT_W-1:0]  pred_o,
  output logic [STAT_W-1:0] long_cnt_o,
  output logic [STAT_W-1:0] period_cnt_o
);
  localparam int BE_W  = TR_W + 1;
  localparam int CMP_W = (CNT_W > BE_W) ? CNT_W : BE_W;
  localparam int NSTAT = 2;

  logic [CNT_W-1:0]  idle_cnt;
  logic              period_end;
  logic [CNT_W-1:0]  period_len;
  logic [CNT_W-1:0]  pred;
  logic [CMP_W-1:0]  brk_even;
  logic              is_long;
  logic [NSTAT-1:0]  stat_inc;
  logic [STAT_W-1:0] stat_cnt [NSTAT];

  // break-even: entry cost plus exit cost
  assign brk_even = CMP_W'(t_enter_i) + CMP_W'(t_exit_i);
  assign is_long  = CMP_W'(period_len) > brk_even;

  sgov_idle_tracker #(.CNT_W(CNT_W)) u_track (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .busy_i      (busy_i),
    .idle_cnt_o  (idle_cnt),
    .period_end_o(period_end),
    .period_len_o(period_len)
  );

  sgov_predictor #(.CNT_W(CNT_W), .SHIFT(PRED_SHIFT)) u_pred (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .upd_i (period_end),
    .len_i (period_len),
    .pred_o(pred)
  );

  sgov_policy #(.CMP_W(CMP_W)) u_pol (
    .busy_i    (busy_i),
    .policy_i  (policy_e'(policy_i)),
    .idle_cnt_i(CMP_W'(idle_cnt)),
    .timeout_i (CMP_W'(timeout_i)),
    .pred_i    (CMP_W'(pred)),
    .brk_even_i(brk_even),
    .req_o     (sleep_req_o)
  );

  // slot 0: every ended period, slot 1: periods beyond break-even
  assign stat_inc[0] = period_end;
  assign stat_inc[1] = period_end && is_long;

  for (genvar g = 0; g < NSTAT; g++) begin : g_stat
    sgov_stat_cnt #(.W(STAT_W)) u_cnt (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .inc_i (stat_inc[g]),
      .cnt_o (stat_cnt[g])
    );
  end

  assign idle_cnt_o   = idle_cnt;
  assign pred_o       = pred;
  assign period_cnt_o = stat_cnt[0];
  assign long_cnt_o   = stat_cnt[1];
endmodule

// File: rtl/sgov_checker.sv
module sgov_checker #(
  parameter int CNT_W  = 16,
  parameter int STAT_W = 16
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              busy_i,
  input logic [1:0]        policy_i,
  input logic              sleep_req_o,
  input logic [CNT_W-1:0]  idle_cnt_o,
  input logic [CNT_W-1:0]  pred_o,
  input logic [STAT_W-1:0] long_cnt_o,
  input logic [STAT_W-1:0] period_cnt_o
);
  localparam logic [CNT_W-1:0]  CMax = {CNT_W{1'b1}};
  localparam logic [STAT_W-1:0] SMax = {STAT_W{1'b1}};

  p_idle_inc_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && idle_cnt_o != CMax) |=> idle_cnt_o == CNT_W'($past(idle_cnt_o) + 1'b1));

  p_idle_sat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && idle_cnt_o == CMax) |=> idle_cnt_o == CMax);

  p_idle_clr_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> idle_cnt_o == '0);

  p_busy_no_req_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |-> !sleep_req_o);

  p_imm_req_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (policy_i == 2'b00 && !busy_i) |-> sleep_req_o);

  p_off_no_req_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    policy_i == 2'b11 |-> !sleep_req_o);

  p_pred_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_i && idle_cnt_o != '0) |=> $stable(pred_o));

  p_long_sub_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_i && idle_cnt_o != '0) |=> $stable(long_cnt_o));

  p_period_inc_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && idle_cnt_o != '0 && period_cnt_o != SMax)
      |=> period_cnt_o == STAT_W'($past(period_cnt_o) + 1'b1));

  p_stat_sat_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (period_cnt_o == SMax) |=> period_cnt_o == SMax);
endmodule

bind idle_sleep_governor sgov_checker #(.CNT_W(CNT_W), .STAT_W(STAT_W)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .busy_i      (busy_i),
  .policy_i    (policy_i),
  .sleep_req_o (sleep_req_o),
  .idle_cnt_o  (idle_cnt_o),
  .pred_o      (pred_o),
  .long_cnt_o  (long_cnt_o),
  .period_cnt_o(period_cnt_o)
);

// File: tb/idle_sleep_governor_test.sv
`timescale 1ns/1ps
module idle_sleep_governor_test;
  localparam int CNT_W  = 10;
  localparam int TR_W   = 8;
  localparam int STAT_W = 4;
  localparam int CMAX   = (1 << CNT_W) - 1;
  localparam int SMAX   = (1 << STAT_W) - 1;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              busy = 1'b1;
  logic [1:0]        policy = 2'b11;
  logic [CNT_W-1:0]  timeout = '0;
  logic [TR_W-1:0]   t_enter = 8'd10;
  logic [TR_W-1:0]   t_exit = 8'd20;
  logic              sleep_req;
  logic [CNT_W-1:0]  idle_cnt;
  logic [CNT_W-1:0]  pred;
  logic [STAT_W-1:0] long_cnt;
  logic [STAT_W-1:0] period_cnt;

  int checks = 0;
  int fails = 0;
  int m_pred = 0;
  int m_long = 0;
  int m_per = 0;

  always #4 clk = ~clk;

  idle_sleep_governor #(.CNT_W(CNT_W), .TR_W(TR_W), .STAT_W(STAT_W)) uut (
    .clk_i(clk), .rst_ni(rst_n), .busy_i(busy), .policy_i(policy),
    .timeout_i(timeout), .t_enter_i(t_enter), .t_exit_i(t_exit),
    .sleep_req_o(sleep_req), .idle_cnt_o(idle_cnt), .pred_o(pred),
    .long_cnt_o(long_cnt), .period_cnt_o(period_cnt)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int brk_even();
    return int'(t_enter) + int'(t_exit);
  endfunction

  function automatic int exp_req(input int idx);
    case (policy)
      2'b00:   return 1;
      2'b01:   return (idx >= int'(timeout)) ? 1 : 0;
      2'b10:   return (m_pred > brk_even()) ? 1 : 0;
      default: return 0;
    endcase
  endfunction

  function automatic string pol_tag();
    case (policy)
      2'b00:   return "R4";
      2'b01:   return "R5";
      2'b10:   return "R6";
      default: return "R7";
    endcase
  endfunction

  // one idle period of len cycles, closed by one busy cycle
  task automatic run_period(input int len);
    int eff;
    @(negedge clk);
    busy = 1'b0;
    #1;
    chk(pol_tag(), int'(sleep_req), exp_req(0));
    for (int i = 1; i < len; i++) begin
      @(negedge clk);
      #1;
      chk(pol_tag(), int'(sleep_req), exp_req((i > CMAX) ? CMAX : i));
    end
    @(negedge clk);
    eff = (len > CMAX) ? CMAX : len;
    chk("R2", int'(idle_cnt), eff);
    busy = 1'b1;
    #1;
    chk("R3", int'(sleep_req), 0);
    m_pred = m_pred - (m_pred >> 3) + (eff >> 3);
    if (m_per < SMAX) m_per++;
    if (eff > brk_even() && m_long < SMAX) m_long++;
    @(negedge clk);
    chk("R2", int'(idle_cnt), 0);
    chk("R8", int'(pred), m_pred);
    chk("R9", int'(long_cnt), m_long);
    chk("R10", int'(period_cnt), m_per);
  endtask

  task automatic t_reset();
    #1;
    chk("R1", int'(idle_cnt), 0);
    chk("R1", int'(pred), 0);
    chk("R1", int'(long_cnt), 0);
    chk("R1", int'(period_cnt), 0);
    chk("R1", int'(sleep_req), 0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", int'(period_cnt), 0);
  endtask

  task automatic t_off();
    policy = 2'b11;
    run_period(5);
  endtask

  task automatic t_immediate();
    policy = 2'b00;
    run_period(3);
    run_period(1);
  endtask

  task automatic t_timeout();
    policy = 2'b01;
    timeout = 10'd7;
    run_period(12);
    timeout = 10'd0;
    run_period(2);
  endtask

  task automatic t_break_even_edge();
    policy = 2'b11;
    run_period(30);
    run_period(31);
  endtask

  task automatic t_predictive();
    policy = 2'b10;
    for (int k = 0; k < 6; k++) run_period(80);
    chk("R6", (m_pred > brk_even()) ? 1 : 0, 1);
    run_period(2);
  endtask

  task automatic t_saturate();
    policy = 2'b01;
    timeout = 10'd1000;
    run_period(CMAX + 80);
    policy = 2'b00;
    for (int k = 0; k < 4; k++) run_period(1);
    chk("R11", int'(period_cnt), SMAX);
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    t_reset();
    t_off();
    t_immediate();
    t_timeout();
    t_break_even_edge();
    t_predictive();
    t_saturate();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule